// File: doc/BRIEF.md
# One-Time-Programmable Fuse Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse macro. A caller presents a start address, a byte count and a cell-bank choice while `idle` is high. The sequencer first makes sure the requested bank is selected. If the bank read-back already matches, it skips the write. Otherwise it writes the bank and reads it back to confirm.

It then powers the macro up in a fixed order. The steps are: enable the write mask, close the first power switch, wait a settle interval, close the second switch, and release isolation. It reads each address in turn with a request/ready handshake and streams out the low byte of every returned word. Finally it powers the macro down in exactly the reverse order. A one-cycle `done` pulse ends every request, and `err_busy` rides on that pulse when the run was aborted.

States are `ST_IDLE`, `ST_BANK_CHK`, `ST_BANK_WR`, `ST_BANK_VFY`, `ST_UP_MASK`, `ST_UP_SW1`, `ST_UP_SETTLE`, `ST_UP_SW2`, `ST_UP_OPEN`, `ST_RD_REQ`, `ST_RD_WAIT`, `ST_DN_CLOSE`, `ST_DN_SW2`, `ST_DN_SETTLE`, `ST_DN_SW1`, `ST_DN_MASK` and `ST_FINISH`.

Transitions:
- **Accept:** IDLE moves to FINISH on a zero count, or to BANK_CHK otherwise.
- **Bank check:** BANK_CHK moves to UP_MASK when the read-back matches, else to BANK_WR.
- **Bank write:** BANK_WR moves to BANK_VFY.
- **Bank verify:** BANK_VFY moves to UP_MASK on a match, else to FINISH with an error.
- **Power-up:** the UP_ states advance one per cycle. UP_SETTLE holds for the settle interval. UP_OPEN moves to RD_REQ.
- **Read:** RD_REQ moves to RD_WAIT. RD_WAIT goes back to RD_REQ on ready while bytes remain. It moves to DN_CLOSE on ready for the last byte, or on timeout with an error.
- **Power-down:** the DN_ states advance in the same manner, and DN_MASK moves to FINISH.
- **Finish:** FINISH moves to IDLE, pulsing `done`.

Top module: `otp_read_seq`

## Requirements
- R1: After a non-zero request passes the bank step, `pwr_wmask_en` rises first. `pwr_sw1` rises one cycle later. `pwr_sw2` rises exactly SETTLE_CYC+1 cycles after `pwr_sw1`. `pwr_iso` falls one cycle after `pwr_sw2`. No power output changes in any other order.
- R2: After the last byte or an abort, `pwr_iso` rises first. `pwr_sw2` falls one cycle later. `pwr_sw1` falls exactly SETTLE_CYC+1 cycles after `pwr_sw2`. `pwr_wmask_en` falls one cycle after `pwr_sw1`. `done` pulses in the cycle after that.
- R3: `fuse_req` pulses for one cycle with `fuse_addr` only while `pwr_wmask_en`, `pwr_sw1` and `pwr_sw2` are high and `pwr_iso` is low. A new pulse comes only after the previous one has been answered with ready, which is bit WORD_W-1 of `fuse_word`.
- R4: When ready is sampled high, `out_valid` pulses in the next cycle with `out_byte` equal to `fuse_word[7:0]`. Bits WORD_W-2 down to 8 have no effect on the byte.
- R5: A run of count N starting at address A issues requests to A, A+1, …, A+N-1 (modulo 2^ADDR_W) in increasing order, and yields exactly N bytes.
- R6: Ready must be seen within TIMEOUT_CYC cycles after the cycle of `fuse_req`. If it is not, the run is aborted with no further request or byte. The power-down of R2 still runs, and `err_busy` is high with `done`.
- R7: A request with count 0 raises `done` two cycles after the accepting edge, with `err_busy` low. It makes no bank write, no power change and no fuse request.
- R8: The bank is handled before any power step. If `bank_rd_val` already equals `req_bank`, `bank_wr_en` is never pulsed. Otherwise one `bank_wr_en` pulse carries the bank. A read-back mismatch one cycle after the write ends the request with `err_busy` and `done`, with no power change and no fuse request.
- R9: A request is taken only while `idle` is high, and `req_valid` at any other time has no effect. `done` is a single-cycle pulse, given once per accepted request.
- R10: In reset, `pwr_iso` is high. `pwr_wmask_en`, `pwr_sw1`, `pwr_sw2`, `fuse_req`, `bank_wr_en`, `out_valid`, `done` and `err_busy` are low, and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a read run (taken when idle) |
| req_addr | input | ADDR_W | First fuse address |
| req_len | input | LEN_W | Number of bytes |
| req_bank | input | 1 | Requested cell bank |
| idle | output | 1 | Ready to accept a request |
| bank_wr_en | output | 1 | Bank-select write strobe |
| bank_wr_val | output | 1 | Bank value written |
| bank_rd_val | input | 1 | Bank-select read-back |
| pwr_wmask_en | output | 1 | Write-mask enable for the power controls |
| pwr_sw1 | output | 1 | First power switch |
| pwr_sw2 | output | 1 | Second power switch |
| pwr_iso | output | 1 | Isolation between macro and core (1 = isolated) |
| fuse_req | output | 1 | Read request, ready flag cleared |
| fuse_addr | output | ADDR_W | Address of the current read |
| fuse_word | input | WORD_W | Returned word: ready in the top bit, data in bits 7:0 |
| out_valid | output | 1 | Byte strobe |
| out_byte | output | 8 | Byte read |
| done | output | 1 | One-cycle end-of-request pulse |
| err_busy | output | 1 | Request aborted (valid with done) |

## Verification
The bench runs several request patterns and checks that the power outputs follow the exact timed ramp both ways:
- An already-selected bank with a short latency.
- A bank switch with a latency just inside the ready window.
- A single byte.
- A zero count.
- A run whose macro never answers one address midway, which separates a correct abort from one that returns stale bytes or skips power-down.
- A latency one cycle beyond the window, which pins the timeout boundary.
- A bank that refuses the write, which separates a read-back check from a blind write.

A request arriving mid-run shows whether the busy state shields the run in progress, and a run after each error shows recovery. The returned words carry non-zero upper bits, so a wrong byte lane shows up as a data mismatch.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_BANK_CHK,
        ST_BANK_WR,
        ST_BANK_VFY,
        ST_UP_MASK,
        ST_UP_SW1,
        ST_UP_SETTLE,
        ST_UP_SW2,
        ST_UP_OPEN,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_DN_CLOSE,
        ST_DN_SW2,
        ST_DN_SETTLE,
        ST_DN_SW1,
        ST_DN_MASK,
        ST_FINISH
    } seq_state_t;

    // One power-control action applied at the end of a cycle
    typedef enum logic [3:0] {
        PS_HOLD,
        PS_MASK_ON,
        PS_SW1_ON,
        PS_SW2_ON,
        PS_ISO_OFF,
        PS_ISO_ON,
        PS_SW2_OFF,
        PS_SW1_OFF,
        PS_MASK_OFF
    } pwr_step_t;

endpackage

// File: rtl/otp_pwr_ctl.sv
module otp_pwr_ctl
    import otp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwr_step_t step,
    output logic      wmask_en,
    output logic      sw1,
    output logic      sw2,
    output logic      iso
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmask_en <= 1'b0;
            sw1      <= 1'b0;
            sw2      <= 1'b0;
            iso      <= 1'b1;
        end else begin
            unique case (step)
                PS_HOLD:     ;
                PS_MASK_ON:  wmask_en <= 1'b1;
                PS_SW1_ON:   sw1      <= 1'b1;
                PS_SW2_ON:   sw2      <= 1'b1;
                PS_ISO_OFF:  iso      <= 1'b0;
                PS_ISO_ON:   iso      <= 1'b1;
                PS_SW2_OFF:  sw2      <= 1'b0;
                PS_SW1_OFF:  sw1      <= 1'b0;
                PS_MASK_OFF: wmask_en <= 1'b0;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/otp_cycle_cnt.sv
module otp_cycle_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic hit
);

    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end

    // Set during the LIMIT-th counted cycle
    assign hit = (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int LEN_W       = 12,
    parameter int WORD_W      = 32,
    parameter int SETTLE_CYC  = 1000,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_bank,
    output logic              idle,
    output logic              bank_wr_en,
    output logic              bank_wr_val,
    input  logic              bank_rd_val,
    output logic              pwr_wmask_en,
    output logic              pwr_sw1,
    output logic              pwr_sw2,
    output logic              pwr_iso,
    output logic              fuse_req,
    output logic [ADDR_W-1:0] fuse_addr,
    input  logic [WORD_W-1:0] fuse_word,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              done,
    output logic              err_busy
);

    localparam int RDY_BIT = WORD_W - 1;

    seq_state_t        state, nxt;
    pwr_step_t         step;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              bank_q;
    logic              err_q;
    logic              rdy;
    logic              settle_en, settle_hit;
    logic              wait_en, wait_hit;
    logic              tmo;
    logic              unused_hi;

    assign rdy       = fuse_word[RDY_BIT];
    assign unused_hi = ^fuse_word[RDY_BIT-1:8];
    assign tmo       = (state == ST_RD_WAIT) && !rdy && wait_hit;

    otp_cycle_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!settle_en),
        .en    (settle_en),
        .hit   (settle_hit)
    );

    otp_cycle_cnt #(.LIMIT(TIMEOUT_CYC)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_RD_WAIT),
        .en    (wait_en),
        .hit   (wait_hit)
    );

    otp_pwr_ctl u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .wmask_en (pwr_wmask_en),
        .sw1      (pwr_sw1),
        .sw2      (pwr_sw2),
        .iso      (pwr_iso)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (req_valid)
                    nxt = (req_len == '0) ? ST_FINISH : ST_BANK_CHK;
            ST_BANK_CHK:
                nxt = (bank_rd_val == bank_q) ? ST_UP_MASK : ST_BANK_WR;
            ST_BANK_WR:
                nxt = ST_BANK_VFY;
            ST_BANK_VFY:
                nxt = (bank_rd_val == bank_q) ? ST_UP_MASK : ST_FINISH;
            ST_UP_MASK:
                nxt = ST_UP_SW1;
            ST_UP_SW1:
                nxt = ST_UP_SETTLE;
            ST_UP_SETTLE:
                if (settle_hit)
                    nxt = ST_UP_SW2;
            ST_UP_SW2:
                nxt = ST_UP_OPEN;
            ST_UP_OPEN:
                nxt = ST_RD_REQ;
            ST_RD_REQ:
                nxt = ST_RD_WAIT;
            ST_RD_WAIT:
                if (rdy)
                    nxt = (rem_q == LEN_W'(1)) ? ST_DN_CLOSE : ST_RD_REQ;
                else if (wait_hit)
                    nxt = ST_DN_CLOSE;
            ST_DN_CLOSE:
                nxt = ST_DN_SW2;
            ST_DN_SW2:
                nxt = ST_DN_SETTLE;
            ST_DN_SETTLE:
                if (settle_hit)
                    nxt = ST_DN_SW1;
            ST_DN_SW1:
                nxt = ST_DN_MASK;
            ST_DN_MASK:
                nxt = ST_FINISH;
            ST_FINISH:
                nxt = ST_IDLE;
            default:
                nxt = ST_IDLE;
        endcase
    end

    // Per-state controls
    always_comb begin
        step       = PS_HOLD;
        settle_en  = 1'b0;
        bank_wr_en = 1'b0;
        fuse_req   = 1'b0;
        wait_en    = 1'b0;
        unique case (state)
            ST_BANK_WR:   bank_wr_en = 1'b1;
            ST_UP_MASK:   step = PS_MASK_ON;
            ST_UP_SW1:    step = PS_SW1_ON;
            ST_UP_SETTLE: settle_en = 1'b1;
            ST_UP_SW2:    step = PS_SW2_ON;
            ST_UP_OPEN:   step = PS_ISO_OFF;
            ST_RD_REQ:    fuse_req = 1'b1;
            ST_RD_WAIT:   wait_en = !rdy;
            ST_DN_CLOSE:  step = PS_ISO_ON;
            ST_DN_SW2:    step = PS_SW2_OFF;
            ST_DN_SETTLE: settle_en = 1'b1;
            ST_DN_SW1:    step = PS_SW1_OFF;
            ST_DN_MASK:   step = PS_MASK_OFF;
            default:      ;
        endcase
    end

    assign idle        = (state == ST_IDLE);
    assign bank_wr_val = bank_q;
    assign fuse_addr   = addr_q;

    // Run context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            rem_q     <= '0;
            bank_q    <= 1'b0;
            err_q     <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            done      <= 1'b0;
            err_busy  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= (state == ST_FINISH);
            err_busy  <= (state == ST_FINISH) && err_q;
            if (state == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                rem_q  <= req_len;
                bank_q <= req_bank;
                err_q  <= 1'b0;
            end
            if (state == ST_BANK_VFY && bank_rd_val != bank_q)
                err_q <= 1'b1;
            if (state == ST_RD_WAIT && rdy) begin
                out_valid <= 1'b1;
                out_byte  <= fuse_word[7:0];
                addr_q    <= addr_q + 1'b1;
                rem_q     <= rem_q - 1'b1;
            end
            if (tmo)
                err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/otp_read_seq_chk.sv
module otp_read_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic idle,
    input logic bank_wr_en,
    input logic pwr_wmask_en,
    input logic pwr_sw1,
    input logic pwr_sw2,
    input logic pwr_iso,
    input logic fuse_req,
    input logic out_valid,
    input logic done,
    input logic err_busy
);

    AST_SW1_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_sw1 |-> pwr_wmask_en); // R1

    AST_SW2_NEEDS_SW1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_sw2 |-> pwr_sw1); // R1

    AST_OPEN_NEEDS_SW2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_iso |-> pwr_sw2); // R2

    AST_REQ_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req |-> (!pwr_iso && pwr_sw2 && pwr_sw1 && pwr_wmask_en)); // R3

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req |=> !fuse_req); // R3

    AST_BYTE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!idle && !pwr_iso)); // R4

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |-> done); // R6

    AST_BANK_BEFORE_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_en |-> (pwr_iso && !pwr_wmask_en)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

bind otp_read_seq otp_read_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle         (idle),
    .bank_wr_en   (bank_wr_en),
    .pwr_wmask_en (pwr_wmask_en),
    .pwr_sw1      (pwr_sw1),
    .pwr_sw2      (pwr_sw2),
    .pwr_iso      (pwr_iso),
    .fuse_req     (fuse_req),
    .out_valid    (out_valid),
    .done         (done),
    .err_busy     (err_busy)
);

// File: tb/otp_read_seq_tb.sv
`timescale 1ns/1ps
module otp_read_seq_tb;

    localparam int SETT = 5;
    localparam int TMO  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [10:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        req_bank = 1'b0;
    logic        idle, bank_wr_en, bank_wr_val;
    logic        pwr_wmask_en, pwr_sw1, pwr_sw2, pwr_iso;
    logic        fuse_req, out_valid, done, err_busy;
    logic [10:0] fuse_addr;
    logic [7:0]  out_byte;
    logic [31:0] fuse_word;

    // Fuse macro and bank model state
    logic        bank_reg;
    logic        m_rdy, pend;
    logic [7:0]  m_byte;
    logic [10:0] paddr;
    int          lcnt;
    int          m_lat = 1;
    int          m_hang = -1;
    bit          m_stuck = 1'b0;
    int          bank_wr_cnt = 0;

    // Monitor records
    int cyc = 0;
    int ev_code[$];
    int ev_cyc[$];
    int byte_q[$];
    int addr_q[$];
    int done_cnt = 0, done_cyc = 0, done_err = 0, viol = 0;
    logic p_wm = 1'b0, p_s1 = 1'b0, p_s2 = 1'b0, p_iso = 1'b1;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign fuse_word = {m_rdy, 7'h6A, 16'hC3A5, m_byte};

    otp_read_seq #(.SETTLE_CYC(SETT), .TIMEOUT_CYC(TMO)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_bank     (req_bank),
        .idle         (idle),
        .bank_wr_en   (bank_wr_en),
        .bank_wr_val  (bank_wr_val),
        .bank_rd_val  (bank_reg),
        .pwr_wmask_en (pwr_wmask_en),
        .pwr_sw1      (pwr_sw1),
        .pwr_sw2      (pwr_sw2),
        .pwr_iso      (pwr_iso),
        .fuse_req     (fuse_req),
        .fuse_addr    (fuse_addr),
        .fuse_word    (fuse_word),
        .out_valid    (out_valid),
        .out_byte     (out_byte),
        .done         (done),
        .err_busy     (err_busy)
    );

    function automatic logic [7:0] fb(input int a);
        return 8'((a * 37) + 11);
    endfunction

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        if (!rst_n) begin
            bank_reg <= 1'b0;
            m_rdy    <= 1'b0;
            m_byte   <= 8'h00;
            pend     <= 1'b0;
            lcnt     <= 0;
            paddr    <= '0;
        end else begin
            if (bank_wr_en) begin
                bank_wr_cnt++;
                if (!m_stuck) bank_reg <= bank_wr_val;
            end
            if (fuse_req) begin
                m_rdy <= 1'b0;
                pend  <= 1'b1;
                lcnt  <= 1;
                paddr <= fuse_addr;
            end else if (pend) begin
                if (lcnt >= m_lat) begin
                    pend <= 1'b0;
                    if (int'(paddr) != m_hang) begin
                        m_rdy  <= 1'b1;
                        m_byte <= fb(int'(paddr));
                    end
                end else begin
                    lcnt <= lcnt + 1;
                end
            end
        end
    end

    // Per-cycle observation away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pwr_wmask_en && !p_wm) begin ev_code.push_back(1); ev_cyc.push_back(cyc); end
            if (pwr_sw1 && !p_s1)      begin ev_code.push_back(2); ev_cyc.push_back(cyc); end
            if (pwr_sw2 && !p_s2)      begin ev_code.push_back(3); ev_cyc.push_back(cyc); end
            if (!pwr_iso && p_iso)     begin ev_code.push_back(4); ev_cyc.push_back(cyc); end
            if (pwr_iso && !p_iso)     begin ev_code.push_back(5); ev_cyc.push_back(cyc); end
            if (!pwr_sw2 && p_s2)      begin ev_code.push_back(6); ev_cyc.push_back(cyc); end
            if (!pwr_sw1 && p_s1)      begin ev_code.push_back(7); ev_cyc.push_back(cyc); end
            if (!pwr_wmask_en && p_wm) begin ev_code.push_back(8); ev_cyc.push_back(cyc); end
            p_wm = pwr_wmask_en; p_s1 = pwr_sw1; p_s2 = pwr_sw2; p_iso = pwr_iso;
            if (out_valid) byte_q.push_back(int'(out_byte));
            if (fuse_req) begin
                addr_q.push_back(int'(fuse_addr));
                if (!(pwr_wmask_en && pwr_sw1 && pwr_sw2 && !pwr_iso) || pend) viol++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
                done_err = int'(err_busy);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    // One request, then all of its checks
    task automatic run(input int st, input int n, input bit bk, input int lat,
                       input int hang, input bit stuck, input int extra_at);
        int  e0 = ev_code.size();
        int  b0 = byte_q.size();
        int  a0 = addr_q.size();
        int  d0 = done_cnt;
        int  w0 = bank_wr_cnt;
        int  v0 = viol;
        bit  bank_was = bank_reg;
        bit  bank_fail;
        bit  active;
        int  tmo_idx = -1;
        int  exp_b[$];
        int  exp_req;
        int  exp_wr;
        int  c0;
        int  w = 0;
        int  ecodes[8] = '{1, 2, 3, 4, 5, 6, 7, 8};
        m_lat = lat; m_hang = hang; m_stuck = stuck;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 11'(st); req_len = 12'(n); req_bank = bk;
        c0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt == d0 && w < 4000) begin
            @(negedge clk);
            w++;
            if (extra_at > 0 && w == extra_at) begin
                req_valid = 1'b1; req_addr = 11'h100; req_len = 12'd1; req_bank = !bk;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        if (done_cnt == d0) begin
            chk(1'b0, "R9", "watchdog: no done", 0, 1);
            finish_up();
        end
        repeat (3) @(negedge clk);

        bank_fail = (n != 0) && (bank_was != bk) && stuck;
        active    = (n != 0) && !bank_fail;
        exp_wr    = (n != 0 && bank_was != bk) ? 1 : 0;
        if (active) begin
            for (int i = 0; i < n; i++) begin
                int a = (st + i) % 2048;
                if (a == hang || lat >= TMO) begin
                    tmo_idx = i;
                    break;
                end
                exp_b.push_back(int'(fb(a)));
            end
        end
        exp_req = exp_b.size() + ((tmo_idx >= 0) ? 1 : 0);

        chk(byte_q.size() - b0 == exp_b.size(), "R5", "byte count", byte_q.size() - b0, exp_b.size());
        for (int i = 0; i < exp_b.size() && b0 + i < byte_q.size(); i++)
            chk(byte_q[b0 + i] == exp_b[i], "R4", "byte value", byte_q[b0 + i], exp_b[i]);
        chk(addr_q.size() - a0 == exp_req, "R5", "request count", addr_q.size() - a0, exp_req);
        for (int i = 0; i < exp_req && a0 + i < addr_q.size(); i++)
            chk(addr_q[a0 + i] == (st + i) % 2048, "R5", "request address", addr_q[a0 + i], (st + i) % 2048);
        chk(done_err == int'(bank_fail || tmo_idx >= 0), "R6", "err_busy with done",
            done_err, int'(bank_fail || tmo_idx >= 0));
        chk(viol == v0, "R3", "handshake or power violations", viol - v0, 0);
        chk(bank_wr_cnt - w0 == exp_wr, "R8", "bank writes", bank_wr_cnt - w0, exp_wr);
        chk(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
        if (active) begin
            chk(ev_code.size() - e0 == 8, "R1", "power event count", ev_code.size() - e0, 8);
            if (ev_code.size() - e0 == 8) begin
                for (int i = 0; i < 8; i++)
                    chk(ev_code[e0 + i] == ecodes[i], (i < 4) ? "R1" : "R2", "power event order",
                        ev_code[e0 + i], ecodes[i]);
                chk(ev_cyc[e0 + 1] - ev_cyc[e0] == 1, "R1", "mask to sw1 gap", ev_cyc[e0 + 1] - ev_cyc[e0], 1);
                chk(ev_cyc[e0 + 2] - ev_cyc[e0 + 1] == SETT + 1, "R1", "sw1 to sw2 gap",
                    ev_cyc[e0 + 2] - ev_cyc[e0 + 1], SETT + 1);
                chk(ev_cyc[e0 + 3] - ev_cyc[e0 + 2] == 1, "R1", "sw2 to open gap", ev_cyc[e0 + 3] - ev_cyc[e0 + 2], 1);
                chk(ev_cyc[e0 + 5] - ev_cyc[e0 + 4] == 1, "R2", "close to sw2 off gap", ev_cyc[e0 + 5] - ev_cyc[e0 + 4], 1);
                chk(ev_cyc[e0 + 6] - ev_cyc[e0 + 5] == SETT + 1, "R2", "sw2 off to sw1 off gap",
                    ev_cyc[e0 + 6] - ev_cyc[e0 + 5], SETT + 1);
                chk(ev_cyc[e0 + 7] - ev_cyc[e0 + 6] == 1, "R2", "sw1 off to mask off gap", ev_cyc[e0 + 7] - ev_cyc[e0 + 6], 1);
                chk(done_cyc - ev_cyc[e0 + 7] == 1, "R2", "mask off to done gap", done_cyc - ev_cyc[e0 + 7], 1);
            end
        end else begin
            chk(ev_code.size() == e0, "R8", "no power change", ev_code.size() - e0, 0);
        end
        if (n == 0)
            chk(done_cyc - c0 == 2, "R7", "zero-count done latency", done_cyc - c0, 2);
        chk(pwr_iso && !pwr_sw1 && !pwr_sw2 && !pwr_wmask_en && idle && !done, "R2",
            "powered down and idle after done", int'({pwr_iso, pwr_sw1, pwr_sw2, pwr_wmask_en, idle, done}), 6'b100010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(pwr_iso == 1'b1, "R10", "pwr_iso in reset", int'(pwr_iso), 1);
        chk({pwr_wmask_en, pwr_sw1, pwr_sw2} == 3'b000, "R10", "switches in reset",
            int'({pwr_wmask_en, pwr_sw1, pwr_sw2}), 0);
        chk({fuse_req, bank_wr_en, out_valid, done, err_busy} == 5'b0, "R10", "strobes in reset",
            int'({fuse_req, bank_wr_en, out_valid, done, err_busy}), 0);
        chk(idle == 1'b1, "R10", "idle in reset", int'(idle), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(16'h010, 4, 1'b0, 1, -1, 1'b0, 0);        // R1 R2 R4 R5, bank already selected (R8)
        run(16'h7FC, 6, 1'b1, TMO - 1, -1, 1'b0, 0);  // R8 bank switch, R6 latency at window edge, R5 wrap
        run(16'h3A0, 1, 1'b1, 3, -1, 1'b0, 0);        // single byte
        run(16'h055, 0, 1'b0, 1, -1, 1'b0, 0);        // R7 zero count
        run(16'h020, 5, 1'b1, 2, 16'h022, 1'b0, 0);   // R6 abort midway
        run(16'h030, 3, 1'b1, TMO, -1, 1'b0, 0);      // R6 latency one beyond window
        run(16'h040, 2, 1'b0, 1, -1, 1'b1, 0);        // R8 read-back mismatch
        run(16'h050, 3, 1'b1, 2, -1, 1'b0, 4);        // R9 request while busy ignored
        run(16'h5EA, 2, 1'b1, 1, -1, 1'b0, 0);        // recovery after errors
        finish_up();
    end

    initial begin
        #(8 * 150000);
        chk(1'b0, "R9", "global watchdog", 0, 1);
        finish_up();
    end

endmodule